// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block is the digital control core of a half-bridge gate driver for a synchronous buck stage. It receives a decoded three-level PWM command, an active-low brake pin, a supply-good flag and a zero-current comparator flag. From these it produces the enables for the high-side and low-side gate drivers. Two feedback flags report when each gate has actually fallen below its threshold. The block uses them to enforce break-before-make, adding a programmable turn-on delay after the opposite gate is seen to be off. All analog quantities reach it as already-decoded digital flags. Every time window counts cycles of the reference clock.

The mid level of the PWM command has two meanings, and a mode latch chooses between them. The latch is armed once per power-up by the brake pin. In brake mode, a mid command turns both switches off at once. In diode-emulation mode, the low side stays on after a mid command. It is released either when the zero-current flag asserts after a leading-edge blanking window, or when a timeout expires, which leaves the switch node floating. Losing supply-good clears the latch.

Top module: `buck_gate_seq`

## Requirements
- R1: With `pwm_cmd` = 2'b01 the high-side enable comes on and stays on. With `pwm_cmd` = 2'b00 the low-side enable comes on and stays on. Each case assumes the non-overlap condition of R2 is met. The two enables are never high in the same cycle.
- R2: An enable rises only in the cycle after a run of DLY_CYC consecutive cycles. During that run the opposite enable was low and the opposite feedback flag reported its gate below threshold.
- R3: When the command stops requesting a gate, that gate's enable falls in the same cycle. This includes the high side on a mid command (2'b10, or 2'b11 which is treated as mid).
- R4: While `brake_n` is low, both enables are low in the same cycle, whatever the command.
- R5: While `rst_n` is low (after the reset edge) or `supply_ok` is low, both enables are low.
- R6: Diode-emulation mode is entered in either of two cases. The first is `brake_n` low for EMU_MIN_CYC consecutive cycles while `supply_ok` is high. The second is `brake_n` low in the first cycle in which `supply_ok` is seen high. A shorter low pulse leaves the block in brake mode.
- R7: Once entered, diode-emulation mode is kept through any later brake activity. It is cleared only when `supply_ok` goes low or by reset.
- R8: In brake mode, a mid command turns the low-side enable off in the same cycle.
- R9: In diode-emulation mode, entering mid keeps the low side requested. The low-side enable falls one cycle after a cycle in which `zero_cur` is high and blanking has elapsed.
- R10: `zero_cur` is ignored until the low-side enable has been high for BLANK_CYC cycles. With `zero_cur` held high, the low side stays on for exactly BLANK_CYC+1 cycles.
- R11: In diode-emulation mode with no zero-current detection, a low-side enable that is already on stays on for TMO_CYC+2 cycles, counted from the first mid cycle. It then falls.
- R12: Leaving mid cancels any pending release. Re-entering mid starts a fresh timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above its lockout threshold |
| brake_n | input | 1 | Active-low brake; low pulses after power-up arm emulation mode |
| pwm_cmd | input | 2 | Decoded PWM: 00 low, 01 high, 10/11 mid |
| zero_cur | input | 1 | Zero-current comparator flag |
| hs_fb_low | input | 1 | High-side gate is below its threshold |
| ls_fb_low | input | 1 | Low-side gate is below its threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with DLY_CYC=3, BLANK_CYC=6, TMO_CYC=40 and EMU_MIN_CYC=3. Short windows like these let the blanking window and the timeout expire many times within a brief random run, and leave some command holds longer than the timeout. With a three-cycle arming threshold, brake pulses of one and two cycles can be driven to show they do not arm emulation mode. The exact boundary pulse is also driven to show that it does.

// File: rtl/bgs_pkg.sv
// Shared types for the buck gate sequencer.
// Assumes the PWM level has already been decoded into a 2-bit code.
package bgs_pkg;
    typedef enum logic [1:0] {
        CMD_LO      = 2'b00,
        CMD_HI      = 2'b01,
        CMD_MID     = 2'b10,
        CMD_MID_ALT = 2'b11
    } pwm_cmd_e;

    // Both codes with the upper bit set mean "mid level".
    function automatic logic cmd_is_mid(input logic [1:0] c);
        return c[1];
    endfunction
endpackage

// File: rtl/bgs_win_timer.sv
// Saturating run-length timer. It counts consecutive cycles in which
// `run` is high and clears whenever `run` is low. `done` is high once
// LIMIT such cycles have been seen.
// Assumes LIMIT >= 1.
module bgs_win_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count the run length, holding at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/bgs_mode_latch.sv
// Power-up mode latch. Emulation mode is armed by a brake-low run of
// EMU_MIN_CYC cycles while the supply is good, or by brake low in the
// first supply-good cycle. It is cleared only by losing the supply or
// by reset.
// Assumes brake_n and supply_ok are already synchronous to clk.
module bgs_mode_latch #(
    parameter int EMU_MIN_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic brake_n,
    output logic emu_mode
);
    logic sup_q;
    logic low_done;
    logic emu_q;

    bgs_win_timer #(.LIMIT(EMU_MIN_CYC)) u_low_run (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (supply_ok & ~brake_n),
        .done  (low_done)
    );

    // Track the supply and set the sticky mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q <= 1'b0;
            emu_q <= 1'b0;
        end else begin
            sup_q <= supply_ok;
            emu_q <= supply_ok & (emu_q | low_done | (~brake_n & ~sup_q));
        end
    end

    assign emu_mode = emu_q;

    // R7
    emu_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(emu_q) |-> (!$past(supply_ok) || !$past(rst_n)));
endmodule

// File: rtl/bgs_gate_arm.sv
// One side of the half bridge. The gate may turn on only after the
// opposite enable has been off, with its feedback flag low, for DLY_CYC
// cycles. Turn-off follows the request in the same cycle.
// Assumes the opposite side's requests never overlap with this one.
module bgs_gate_arm #(
    parameter int DLY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic opp_en,
    input  logic opp_fb_low,
    output logic en
);
    logic ready;
    logic on_q;

    bgs_win_timer #(.LIMIT(DLY_CYC)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (opp_fb_low & ~opp_en),
        .done  (ready)
    );

    // Hold the gate on while requested; start it only when ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
        end else begin
            on_q <= want & (on_q | ready);
        end
    end

    assign en = on_q & want;

    // R2
    nonovl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (!$past(opp_en) && !opp_en));
endmodule

// File: rtl/buck_gate_seq.sv
// Gate control sequencer for a synchronous buck half bridge.
// It decodes the PWM command into per-side requests, applies brake and
// supply gating, and runs the diode-emulation hold with its blanking
// and timeout windows. Index 0 is the high side, index 1 the low side.
// Assumes all inputs are synchronous to clk.
module buck_gate_seq #(
    parameter int DLY_CYC     = 4,
    parameter int BLANK_CYC   = 38,
    parameter int TMO_CYC     = 7500,
    parameter int EMU_MIN_CYC = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       brake_n,
    input  logic [1:0] pwm_cmd,
    input  logic       zero_cur,
    input  logic       hs_fb_low,
    input  logic       ls_fb_low,
    output logic       hs_en,
    output logic       ls_en
);
    import bgs_pkg::*;

    localparam int SIDES = 2;

    logic             emu;
    logic             gate_ok;
    logic             is_mid;
    logic             mid_q;
    logic             hold_q;
    logic             blank_done;
    logic             tmo_done;
    logic [SIDES-1:0] want;
    logic [SIDES-1:0] en;
    logic [SIDES-1:0] fb_low;

    bgs_mode_latch #(.EMU_MIN_CYC(EMU_MIN_CYC)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .brake_n   (brake_n),
        .emu_mode  (emu)
    );

    assign gate_ok = supply_ok & brake_n;
    assign is_mid  = cmd_is_mid(pwm_cmd);

    // Per-side requests from the command, the mode and the hold state.
    always_comb begin
        want[0] = gate_ok & (pwm_cmd == CMD_HI);
        want[1] = gate_ok & ((pwm_cmd == CMD_LO) |
                             (is_mid & emu & (hold_q | ~mid_q)));
    end

    bgs_win_timer #(.LIMIT(BLANK_CYC)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en[1]),
        .done  (blank_done)
    );

    bgs_win_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hold_q),
        .done  (tmo_done)
    );

    // Emulation hold: set on entry to mid, dropped on zero current or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            mid_q  <= is_mid;
            hold_q <= gate_ok & emu & is_mid &
                      (~mid_q | (hold_q & ~(zero_cur & blank_done) & ~tmo_done));
        end
    end

    assign fb_low = {ls_fb_low, hs_fb_low};

    for (genvar g = 0; g < SIDES; g++) begin : g_arm
        bgs_gate_arm #(.DLY_CYC(DLY_CYC)) u_arm (
            .clk        (clk),
            .rst_n      (rst_n),
            .want       (want[g]),
            .opp_en     (en[SIDES-1-g]),
            .opp_fb_low (fb_low[SIDES-1-g]),
            .en         (en[g])
        );
    end

    assign hs_en = en[0];
    assign ls_en = en[1];

    // R1
    mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R4
    brake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !brake_n |-> (!hs_en && !ls_en));

    // R10
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !blank_done && !tmo_done && is_mid && gate_ok && emu) |=> hold_q);
endmodule

// File: tb/buck_gate_seq_tb.sv
module buck_gate_seq_tb;
    localparam int DLY   = 3;
    localparam int BLANK = 6;
    localparam int TMO   = 40;
    localparam int EMIN  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b1;
    logic       brake_n = 1'b1;
    logic [1:0] pwm_cmd = 2'b00;
    logic       zero_cur = 1'b0;
    logic       hs_en, ls_en;
    logic       hd1 = 1'b0, hd2 = 1'b0, ld1 = 1'b0, ld2 = 1'b0;
    logic       hs_fb_low, ls_fb_low;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    // Gate feedback: a gate reads as low two cycles after its enable drops.
    assign hs_fb_low = !hd1 && !hd2;
    assign ls_fb_low = !ld1 && !ld2;
    always @(posedge clk) begin
        hd1 <= hs_en; hd2 <= hd1;
        ld1 <= ls_en; ld2 <= ld1;
    end

    buck_gate_seq #(
        .DLY_CYC(DLY), .BLANK_CYC(BLANK), .TMO_CYC(TMO), .EMU_MIN_CYC(EMIN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .brake_n(brake_n),
        .pwm_cmd(pwm_cmd), .zero_cur(zero_cur), .hs_fb_low(hs_fb_low),
        .ls_fb_low(ls_fb_low), .hs_en(hs_en), .ls_en(ls_en)
    );

    // Cycle model of the requirements.
    bit m_emu, m_supq, m_midq, m_hold, m_hon, m_lon;
    int m_lowcnt, m_tmo, m_blank, m_hcnt, m_lcnt;

    function automatic int sat(int v, int lim);
        return (v < lim) ? v + 1 : lim;
    endfunction
    function automatic bit f_ok();
        return supply_ok && brake_n;
    endfunction
    function automatic bit w_hs();
        return f_ok() && pwm_cmd == 2'b01;
    endfunction
    function automatic bit w_ls();
        return f_ok() && (pwm_cmd == 2'b00 ||
               (pwm_cmd[1] && m_emu && (m_hold || !m_midq)));
    endfunction
    function automatic bit exp_hs();
        return m_hon && w_hs();
    endfunction
    function automatic bit exp_ls();
        return m_lon && w_ls();
    endfunction

    always @(posedge clk) begin : model
        bit eh, el, bd, td, lowdone;
        if (!rst_n) begin
            m_emu <= 0; m_supq <= 0; m_midq <= 0; m_hold <= 0; m_hon <= 0; m_lon <= 0;
            m_lowcnt <= 0; m_tmo <= 0; m_blank <= 0; m_hcnt <= 0; m_lcnt <= 0;
        end else begin
            eh = exp_hs(); el = exp_ls();
            bd = (m_blank == BLANK); td = (m_tmo == TMO); lowdone = (m_lowcnt == EMIN);
            m_emu    <= supply_ok && (m_emu || lowdone || (!brake_n && !m_supq));
            m_supq   <= supply_ok;
            m_lowcnt <= (supply_ok && !brake_n) ? sat(m_lowcnt, EMIN) : 0;
            m_midq   <= pwm_cmd[1];
            m_hold   <= f_ok() && m_emu && pwm_cmd[1] &&
                        (!m_midq || (m_hold && !(zero_cur && bd) && !td));
            m_tmo    <= m_hold ? sat(m_tmo, TMO) : 0;
            m_blank  <= el ? sat(m_blank, BLANK) : 0;
            m_hcnt   <= (ls_fb_low && !el) ? sat(m_hcnt, DLY) : 0;
            m_lcnt   <= (hs_fb_low && !eh) ? sat(m_lcnt, DLY) : 0;
            m_hon    <= w_hs() && (m_hon || m_hcnt == DLY);
            m_lon    <= w_ls() && (m_lon || m_lcnt == DLY);
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: compare against the model, then move to the next drive point.
    task automatic cyc(string tag);
        #1;
        chk(tag, "hs_en", hs_en, exp_hs());
        chk(tag, "ls_en", ls_en, exp_ls());
        @(negedge clk);
    endtask

    task automatic run_n(int n, string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic expect_now(string tag, logic h, logic l);
        #1;
        chk(tag, "hs_en", hs_en, h);
        chk(tag, "ls_en", ls_en, l);
        @(negedge clk);
    endtask

    task automatic count_ls(int n, string tag, output int on);
        on = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            chk(tag, "hs_en", hs_en, exp_hs());
            chk(tag, "ls_en", ls_en, exp_ls());
            if (ls_en) on++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int on;
        int blow;
        int hold;
        void'($urandom(32'd5311));
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R5: outputs are off while held in reset
        expect_now("R5", 1'b0, 1'b0);
        rst_n = 1'b1;

        // R1 / R2: high side after non-overlap
        pwm_cmd = 2'b01; run_n(12, "R2");
        expect_now("R1", 1'b1, 1'b0);

        // R2: low side rises exactly DLY+3 cycles after the command change
        pwm_cmd = 2'b00;
        for (int k = 0; k <= DLY + 3; k++) begin
            #1;
            chk("R2", "ls_en", ls_en, k == DLY + 3);
            chk("R3", "hs_en", hs_en, 1'b0);
            @(negedge clk);
        end
        run_n(10, "R1");
        expect_now("R1", 1'b0, 1'b1);

        // R8: brake mode, mid drops the low side at once
        pwm_cmd = 2'b10; expect_now("R8", 1'b0, 1'b0);
        run_n(5, "R8");

        // R3: mid alternate code drops the high side at once
        pwm_cmd = 2'b01; run_n(12, "R3");
        pwm_cmd = 2'b11; expect_now("R3", 1'b0, 1'b0);

        // R4: one-cycle brake forces off and must not arm emulation (R6)
        pwm_cmd = 2'b00; run_n(12, "R4");
        brake_n = 1'b0; expect_now("R4", 1'b0, 1'b0);
        brake_n = 1'b1; run_n(12, "R4");
        pwm_cmd = 2'b10; expect_now("R6", 1'b0, 1'b0);
        run_n(3, "R6");

        // Random brake-mode traffic with sub-threshold brake pulses
        blow = 0;
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 6 == 0) pwm_cmd = 2'($urandom % 4);
            if (blow > 0) begin
                brake_n = 1'b0; blow--;
            end else begin
                brake_n = 1'b1;
                if ($urandom % 40 == 0) blow = 1 + int'($urandom % (EMIN - 1));
            end
            zero_cur = 1'($urandom % 2);
            cyc("R8");
        end
        brake_n = 1'b1; zero_cur = 1'b0;
        pwm_cmd = 2'b00; run_n(15, "R8");
        pwm_cmd = 2'b10; expect_now("R6", 1'b0, 1'b0);

        // R6: a brake pulse of exactly EMIN cycles arms emulation
        pwm_cmd = 2'b00; run_n(15, "R1");
        brake_n = 1'b0; run_n(EMIN, "R4");
        brake_n = 1'b1; run_n(15, "R1");
        // R11: the timeout releases the low side after TMO+2 cycles
        pwm_cmd = 2'b10; count_ls(TMO + 10, "R11", on);
        chk("R11", "ls_on_cycles", on == TMO + 2, 1'b1);
        if (on != TMO + 2) $display("FAIL R11 on-cycles actual=%0d expected=%0d", on, TMO + 2);

        // R12: leaving mid and re-entering restarts the timeout
        pwm_cmd = 2'b00; run_n(15, "R12");
        pwm_cmd = 2'b10; run_n(10, "R12");
        pwm_cmd = 2'b00; run_n(5, "R12");
        pwm_cmd = 2'b10; count_ls(TMO + 10, "R12", on);
        chk("R12", "ls_on_cycles", on == TMO + 2, 1'b1);

        // R9: zero current after blanking releases on the next cycle
        pwm_cmd = 2'b00; run_n(15, "R9");
        pwm_cmd = 2'b10; on = 0;
        for (int k = 0; k < 10; k++) begin
            zero_cur = (k == 3);
            #1;
            chk("R9", "ls_en", ls_en, k <= 3);
            if (ls_en) on++;
            @(negedge clk);
        end
        zero_cur = 1'b0;
        chk("R9", "ls_on_cycles", on == 4, 1'b1);

        // R10: zero held high is ignored through the blanking window
        pwm_cmd = 2'b01; run_n(15, "R10");
        pwm_cmd = 2'b10; zero_cur = 1'b1;
        count_ls(30, "R10", on);
        zero_cur = 1'b0;
        chk("R10", "ls_on_cycles", on == BLANK + 1, 1'b1);
        if (on != BLANK + 1) $display("FAIL R10 on-cycles actual=%0d expected=%0d", on, BLANK + 1);

        // Random emulation-mode traffic with brake pulses
        hold = 0; blow = 0;
        for (int i = 0; i < 1500; i++) begin
            if (hold == 0) begin
                pwm_cmd = 2'($urandom % 4);
                hold = 1 + int'($urandom % 60);
            end
            hold--;
            if (blow > 0) begin
                brake_n = 1'b0; blow--;
            end else begin
                brake_n = 1'b1;
                if ($urandom % 80 == 0) blow = 1 + int'($urandom % 5);
            end
            zero_cur = ($urandom % 30 == 0);
            cyc("R9");
        end
        brake_n = 1'b1; zero_cur = 1'b0;

        // R7: mode survives brake activity
        pwm_cmd = 2'b00; run_n(15, "R7");
        pwm_cmd = 2'b10; expect_now("R7", 1'b0, 1'b1);

        // R5 / R7: supply loss forces off and clears the mode
        supply_ok = 1'b0; pwm_cmd = 2'b00; expect_now("R5", 1'b0, 1'b0);
        run_n(5, "R5");
        supply_ok = 1'b1; run_n(15, "R7");
        pwm_cmd = 2'b10; expect_now("R7", 1'b0, 1'b0);

        // R6: brake held low across the supply-good rise arms emulation
        supply_ok = 1'b0; brake_n = 1'b0; pwm_cmd = 2'b00; run_n(3, "R6");
        supply_ok = 1'b1; cyc("R6");
        brake_n = 1'b1; run_n(15, "R6");
        pwm_cmd = 2'b10; expect_now("R6", 1'b0, 1'b1);
        run_n(5, "R6");

        finish_run();
    end
endmodule